// File: doc/BRIEF.md
# Real-Time Clock Prescaler and Update Strobe Generator

This block divides a 4.194304 MHz oscillator clock down through a chain of binary stages. It produces a one-clock update strobe once per second, and that strobe drives the calendar update logic. A second output gives a periodic event pulse taken from one of several intermediate taps of the same chain. A rate-select field picks the tap, from one event every half second down to one every 122.070 microseconds. A value of zero turns the periodic output off.

A three-bit mode field controls the chain. It lets the chain run, holds it cleared so the time can be set precisely, or freezes it at its current count. When the chain goes from cleared to running, it restarts at its midpoint. The first update strobe therefore arrives half a second after release instead of a full second. The number of stages is a parameter, so a shorter chain can stand in for the full one.

Top module: `rtc_divider`

## Requirements
- R1: While `rst_ni` is low, `update_o` and `periodic_o` are 0. After reset the chain is in the same cleared state that the clear codes load.
- R2: With `mode_i` = 3'b010 (run), the chain advances by one on every clock edge.
- R3: In run mode `update_o` is a one-clock pulse that repeats every 2^STAGES clocks.
- R4: Codes 3'b110 and 3'b111 (clear) load the chain to its midpoint. After a change from clear to run, the first update pulse appears on the 2^(STAGES-1)-th run edge, whatever the length of the clear period.
- R5: Codes 3'b000, 3'b001, 3'b011, 3'b100 and 3'b101 (freeze) keep the chain count unchanged. On return to run, counting continues from the frozen value, so the next update is delayed by exactly the freeze length.
- R6: With `rate_i` = r in 1..13 in run mode, `periodic_o` is a one-clock pulse every 2^(STAGES-r) clocks. Each step of r halves the period, and every update pulse coincides with a periodic pulse.
- R7: `rate_i` values 14 and 15 behave like 13 (the fastest tap, period 2^(STAGES-13) clocks).
- R8: With `rate_i` = 0, `periodic_o` stays 0.
- R9: In any mode other than run, both outputs are 0 from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock (4.194304 MHz at STAGES = 22) |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 3 | Chain mode: 3'b010 run, 3'b11x clear, others freeze |
| rate_i | input | RATE_W | Periodic tap select; 0 turns the periodic output off |
| update_o | output | 1 | One-clock update strobe (1 Hz at STAGES = 22) |
| periodic_o | output | 1 | One-clock periodic event pulse |

## Verification
The assertions check on every cycle that:
- the update strobe is one clock wide;
- both outputs stay low in any mode other than run, and the periodic output stays low at rate zero;
- every update strobe is accompanied by a periodic pulse when a tap is selected;
- a clear code leaves the chain at its midpoint and a freeze code leaves the count unchanged.

Only the bench's scenarios can show the half-second delay to the first strobe after release, the full update period, the period of each tap including the clamped rates, and the update delay caused by a freeze. The bench measures these in counted clock edges and compares them with a reference model under random mode and rate sequences.

// File: rtl/rtc_div_pkg.sv
package rtc_div_pkg;

  localparam logic [2:0] MODE_RUN = 3'b010;

  function automatic logic mode_is_run(input logic [2:0] m);
    return m == MODE_RUN;
  endfunction

  function automatic logic mode_is_clear(input logic [2:0] m);
    return m[2:1] == 2'b11;
  endfunction

endpackage

// File: rtl/rtc_div_rst_sync.sv
module rtc_div_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic srst_no
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_no = sync_q[1];

endmodule

// File: rtl/rtc_div_ctrl.sv
module rtc_div_ctrl
  import rtc_div_pkg::*;
(
  input  logic [2:0] mode_i,
  output logic       run_o,
  output logic       clear_o
);

  always_comb begin
    run_o   = mode_is_run(mode_i);
    clear_o = mode_is_clear(mode_i);
  end

endmodule

// File: rtl/rtc_div_chain.sv
module rtc_div_chain #(
  parameter int STAGES = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              clear_i,
  output logic [STAGES-1:0] cnt_o
);

  localparam logic [STAGES-1:0] MIDPOINT = {1'b1, {(STAGES-1){1'b0}}};

  logic [STAGES-1:0] cnt_q;
  logic [STAGES-1:0] cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_en = clear_i | run_i;
    if (clear_i) begin
      cnt_d = MIDPOINT;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= MIDPOINT;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/rtc_div_tap.sv
module rtc_div_tap #(
  parameter int STAGES    = 22,
  parameter int RATE_W    = 4,
  parameter int FAST_RATE = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [STAGES-1:0] cnt_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              update_o,
  output logic              periodic_o
);

  localparam int IDX_W = $clog2(STAGES);
  localparam logic [RATE_W-1:0] FAST = RATE_W'(FAST_RATE);

  // ones_pfx[k] is set when the low k+1 bits of the chain are all ones
  logic [STAGES-1:0] ones_pfx;

  assign ones_pfx[0] = cnt_i[0];
  for (genvar k = 1; k < STAGES; k++) begin : g_pfx
    assign ones_pfx[k] = ones_pfx[k-1] & cnt_i[k];
  end

  logic [RATE_W-1:0] eff_rate;
  logic [IDX_W-1:0]  tap_idx;
  logic              upd_d, per_d;
  logic              upd_q, per_q;

  always_comb begin
    eff_rate = (rate_i > FAST) ? FAST : rate_i;
    tap_idx  = IDX_W'(STAGES - 1) - IDX_W'(eff_rate);
    upd_d    = run_i & ones_pfx[STAGES-1];
    per_d    = run_i & (rate_i != '0) & ones_pfx[tap_idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q <= 1'b0;
      per_q <= 1'b0;
    end else begin
      upd_q <= upd_d;
      per_q <= per_d;
    end
  end

  assign update_o   = upd_q;
  assign periodic_o = per_q;

endmodule

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int STAGES    = 22,
  parameter int RATE_W    = 4,
  parameter int FAST_RATE = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              update_o,
  output logic              periodic_o
);

  logic              srst_n;
  logic              run;
  logic              clear;
  logic [STAGES-1:0] chain_cnt;

  rtc_div_rst_sync u_rst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .srst_no (srst_n)
  );

  rtc_div_ctrl u_ctrl (
    .mode_i  (mode_i),
    .run_o   (run),
    .clear_o (clear)
  );

  rtc_div_chain #(.STAGES(STAGES)) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (srst_n),
    .run_i   (run),
    .clear_i (clear),
    .cnt_o   (chain_cnt)
  );

  rtc_div_tap #(
    .STAGES    (STAGES),
    .RATE_W    (RATE_W),
    .FAST_RATE (FAST_RATE)
  ) u_tap (
    .clk_i      (clk_i),
    .rst_ni     (srst_n),
    .run_i      (run),
    .cnt_i      (chain_cnt),
    .rate_i     (rate_i),
    .update_o   (update_o),
    .periodic_o (periodic_o)
  );

endmodule

// File: rtl/rtc_divider_chk.sv
module rtc_divider_chk
  import rtc_div_pkg::*;
#(
  parameter int STAGES    = 22,
  parameter int RATE_W    = 4,
  parameter int FAST_RATE = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        mode_i,
  input logic [RATE_W-1:0] rate_i,
  input logic              update_o,
  input logic              periodic_o,
  input logic [STAGES-1:0] cnt_i
);

  localparam logic [STAGES-1:0] MIDPOINT = {1'b1, {(STAGES-1){1'b0}}};

  initial begin
    a_r6_tap_fits: assert (FAST_RATE < STAGES && FAST_RATE < (1 << RATE_W));
  end

  a_r3_update_one_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |=> !update_o);

  a_r9_quiet_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_is_run($past(mode_i)) |-> (!update_o && !periodic_o));

  a_r8_rate_zero_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rate_i) == '0) |-> !periodic_o);

  a_r6_update_has_periodic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_o && ($past(rate_i) != '0)) |-> periodic_o);

  a_r4_clear_loads_midpoint: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_is_clear($past(mode_i)) |-> (cnt_i == MIDPOINT));

  a_r5_freeze_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_is_run($past(mode_i)) && !mode_is_clear($past(mode_i))) |-> $stable(cnt_i));

endmodule

bind rtc_divider rtc_divider_chk #(
  .STAGES    (STAGES),
  .RATE_W    (RATE_W),
  .FAST_RATE (FAST_RATE)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .rate_i     (rate_i),
  .update_o   (update_o),
  .periodic_o (periodic_o),
  .cnt_i      (chain_cnt)
);

// File: tb/rtc_divider_tb_top.sv
module rtc_divider_tb_top;

  localparam int STAGES = 14;
  localparam int RATE_W = 4;
  localparam int FAST   = 13;
  localparam int PERIOD = 1 << STAGES;
  localparam int HALF   = 1 << (STAGES - 1);

  logic              clk;
  logic              rst_n;
  logic [2:0]        mode;
  logic [RATE_W-1:0] rate;
  logic              update;
  logic              periodic;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  rtc_divider #(.STAGES(STAGES), .RATE_W(RATE_W), .FAST_RATE(FAST)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .mode_i     (mode),
    .rate_i     (rate),
    .update_o   (update),
    .periodic_o (periodic)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int tap_period(input logic [RATE_W-1:0] r);
    int e;
    if (r == 0) return 0;
    e = (int'(r) > FAST) ? FAST : int'(r);
    return 1 << (STAGES - e);
  endfunction

  // reference model, written from the requirements
  int m_cnt;
  bit m_upd, m_per;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= HALF;
      m_upd <= 1'b0;
      m_per <= 1'b0;
    end else begin
      automatic bit run = (mode == 3'b010);
      automatic bit clr = (mode[2:1] == 2'b11);
      automatic int p   = tap_period(rate);
      m_upd <= run && (m_cnt == PERIOD - 1);
      m_per <= run && (p != 0) && ((m_cnt % (p == 0 ? 1 : p)) == p - 1);
      m_cnt <= clr ? HALF : (run ? (m_cnt + 1) % PERIOD : m_cnt);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts negedges until the selected output is high; -1 if limit reached
  task automatic edges_to(input bit use_upd, input int limit, output int n);
    bit seen = 0;
    n = 0;
    while (!seen && n < limit) begin
      @(negedge clk);
      n++;
      seen = use_upd ? update : periodic;
    end
    if (!seen) n = -1;
  endtask

  task automatic count_pulses(input int len, output int nu, output int np);
    nu = 0; np = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      nu += int'(update);
      np += int'(periodic);
    end
  endtask

  task automatic tap_interval(input logic [RATE_W-1:0] r, input string req);
    int n;
    int exp = tap_period(r);
    rate = r;
    edges_to(1'b0, 2 * PERIOD, n);   // align to a pulse at the new rate
    edges_to(1'b0, 2 * PERIOD, n);
    check(n == exp, req, n, exp);
  endtask

  initial begin
    int n, nu, np;
    void'($urandom(32'h5eed_0c1d));
    rst_n = 1'b0;
    mode  = 3'b110;
    rate  = '0;
    repeat (5) @(negedge clk);
    check(!update && !periodic, "R1 outputs in reset", int'(update) + int'(periodic), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R9: clear code held, rate selected, nothing comes out
    rate = 4'd3;
    count_pulses(100, nu, np);
    check(nu + np == 0, "R9 clear held quiet", nu + np, 0);

    // R4: release to run, first update after half a period
    mode = 3'b010;
    edges_to(1'b1, 2 * PERIOD, n);
    check(n == HALF, "R4 first update after release", n, HALF);
    @(negedge clk);
    check(!update, "R3 update one clock wide", int'(update), 0);
    edges_to(1'b1, 2 * PERIOD, n);
    check(n == PERIOD - 1, "R3 update period", n + 1, PERIOD);

    // periodic taps
    tap_interval(4'd13, "R2 fastest tap advances each clock");
    tap_interval(4'd14, "R7 rate 14 clamps");
    tap_interval(4'd15, "R7 rate 15 clamps");
    tap_interval(4'd9,  "R6 rate 9");
    tap_interval(4'd5,  "R6 rate 5");
    tap_interval(4'd1,  "R6 rate 1 half second");

    // R8: rate zero
    rate = '0;
    @(negedge clk);
    count_pulses(3000, nu, np);
    check(np == 0, "R8 rate zero quiet", np, 0);

    // R5: freeze right after an update, then resume
    rate = 4'd13;
    edges_to(1'b1, 2 * PERIOD, n);
    mode = 3'b000;
    count_pulses(700, nu, np);
    check(nu + np == 0, "R5 freeze quiet", nu + np, 0);
    mode = 3'b010;
    edges_to(1'b1, 2 * PERIOD, n);
    check(n + 700 == 700 + PERIOD, "R5 freeze delays update", n + 700, 700 + PERIOD);

    // R4: the other clear code mid-run, long hold
    count_pulses(1234, nu, np);
    mode = 3'b111;
    count_pulses(50, nu, np);
    check(nu + np == 0, "R9 clear 111 quiet", nu + np, 0);
    mode = 3'b010;
    edges_to(1'b1, 2 * PERIOD, n);
    check(n == HALF, "R4 release after 111", n, HALF);

    // R1: asynchronous reset mid-run
    count_pulses(100, nu, np);
    mode  = 3'b110;
    rst_n = 1'b0;
    #3;
    check(!update && !periodic, "R1 async reset clears outputs", int'(update) + int'(periodic), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // random segments checked against the model every cycle
    for (int s = 0; s < 30; s++) begin
      int pick = int'($urandom % 20);
      int len  = 1 + int'($urandom % 2000);
      if (pick < 14)      mode = 3'b010;
      else if (pick < 17) mode = (pick == 16) ? 3'b111 : 3'b110;
      else begin
        case ($urandom % 5)
          0: mode = 3'b000;
          1: mode = 3'b001;
          2: mode = 3'b011;
          3: mode = 3'b100;
          default: mode = 3'b101;
        endcase
      end
      rate = RATE_W'($urandom);
      for (int i = 0; i < len; i++) begin
        @(negedge clk);
        check(update == m_upd, "R3 random update", int'(update), int'(m_upd));
        check(periodic == m_per, "R6 random periodic", int'(periodic), int'(m_per));
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule